// File: doc/BRIEF.md
# Clock-Reset Event Flags and Interrupt Enables

This block is the register-mapped status and interrupt unit that sits beside a clock and reset generator. It turns a few raw signals into software-visible state:
- a real-time tick pulse;
- a PLL lock level and a self-clock-mode level;
- pulses that name the cause of a reset (power-on, low voltage, illegal address).

Events are caught in sticky flags that software clears by writing 1 to them. The two levels are also shown live as read-only status bits, and a single interrupt line is raised for every flag whose enable is set.

The lock and self-clock-mode levels come from other clock domains, so each first passes through a flop synchronizer. A change in either direction of the resulting status bit sets the matching change flag. The lock status reads as 0 while self-clock mode is active, so entering or leaving self-clock mode while locked also counts as a lock change.

The bus is a plain one: address, write data, a one-cycle write strobe and combinational read data. The block reset `rst_n` must be driven only by the power-on reset, so that the reset-cause flags survive every other kind of chip reset.

Top module: `clkrst_evt_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the event register resets to 0x40 (only the power-on flag set), the enable register resets to 0x00, and `irq` goes low.
- R2: The event register sits at offset 0x3. Its bits are: 7 tick flag, 6 power-on flag, 5 low-voltage flag, 4 lock-change flag, 3 lock status, 2 illegal-address flag, 1 self-clock-change flag, 0 self-clock status.
- R3: A write to offset 0x3 clears each flag bit (7, 6, 5, 4, 2, 1) whose write-data bit is 1, and leaves alone every flag whose write-data bit is 0.
- R4: A high `rti_tick` at a clock edge sets bit 7 at that edge.
- R5: A high `por_evt`, `lvr_evt` or `ila_evt` at a clock edge sets bit 6, 5 or 2 respectively at that edge.
- R6: The lock status (bit 3) equals the synchronized lock level ANDed with the inverse of the synchronized self-clock level. It appears two edges after the input changes. Any change of the lock status sets bit 4 one edge later.
- R7: The self-clock status (bit 0) follows the synchronized self-clock level two edges after the input. Any change of it sets bit 1 one edge later.
- R8: Bits 3 and 0 ignore writes.
- R9: The enable register sits at offset 0x4. Bit 7 enables the tick interrupt, bit 4 the lock-change interrupt and bit 1 the self-clock-change interrupt. The remaining bits read 0 whatever is written.
- R10: `irq` is high exactly when at least one of flags 7, 4, 1 is set together with its enable bit.
- R11: When a set event and a clearing write reach the same flag at the same edge, the flag ends up set.
- R12: Reads of any offset other than 0x3 and 0x4 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rti_tick | input | 1 | One-cycle pulse at the end of each real-time period |
| por_evt | input | 1 | Pulse: a power-on reset occurred |
| lvr_evt | input | 1 | Pulse: a low-voltage reset occurred |
| ila_evt | input | 1 | Pulse: an illegal-address reset occurred |
| lock_in | input | 1 | Asynchronous PLL lock level |
| scm_in | input | 1 | Asynchronous self-clock-mode level |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets three corner cases.
- A flag hit by a set event and a clearing write at the same edge. A design that lets the clear win would lose a tick.
- Falling edges of the lock level. A detector that watches only for rises would leave the change flag clear when lock is lost.
- Entering self-clock mode while locked. Both change flags must set together and the lock status must read 0; a design that shows the raw lock level would report lock in self-clock mode and miss the lock-change event.

Writes of 0 and writes to the status bits, the unused enable bits and the unmapped offsets are checked through read-back. A design that treats the event register as plain read-write would show the write data there.

// File: rtl/clkrst_pkg.sv
// Package: shared constants for the clock-reset event register block.
// Assumes an 8-bit register file; bit positions are fixed by software.
package clkrst_pkg;
    localparam int REG_W    = 8;
    localparam int FLAG_OFS = 3;
    localparam int IEN_OFS  = 4;

    localparam int B_TICK   = 7;
    localparam int B_POR    = 6;
    localparam int B_LVR    = 5;
    localparam int B_LKCHG  = 4;
    localparam int B_LKST   = 3;
    localparam int B_ILA    = 2;
    localparam int B_SCCHG  = 1;
    localparam int B_SCST   = 0;

    // Bits that are sticky write-one-to-clear flags
    localparam logic [REG_W-1:0] STICKY_MASK = 8'hF6;
    // Bits that are implemented in the enable register (and may interrupt)
    localparam logic [REG_W-1:0] IEN_MASK    = 8'h92;
    // Event register value after power-on reset
    localparam logic [REG_W-1:0] FLAG_RST    = 8'h40;
endpackage

// File: rtl/clkrst_sync.sv
// Module: level synchronizer with a parameterized number of flop stages.
// Assumes d is a slow level from another domain; q resets to 0.
module clkrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic stg;
            // single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= 1'b0;
                else        stg <= d;
            end
            assign q = stg;
        end else begin : g_chain
            logic [STAGES-1:0] stg;
            // shift the level through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], d};
            end
            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/clkrst_chg_det.sv
// Module: any-edge detector; pulses chg for one cycle when lvl differs
// from its value at the previous edge. Assumes lvl resets to 0.
module clkrst_chg_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic chg
);
    logic prev;

    // remember the level seen at the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign chg = lvl ^ prev;
endmodule

// File: rtl/clkrst_w1c_bank.sv
// Module: bank of write-one-to-clear flags. Only bits set in MASK are
// built; others read 0. A set and a clear in the same cycle: set wins.
module clkrst_w1c_bank #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   MASK    = '1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_flag
            logic f;
            // sticky flag, set has priority over clear
            always_ff @(posedge clk) begin
                if (!rst_n)        f <= RST_VAL[i];
                else if (set_i[i]) f <= 1'b1;
                else if (clr_i[i]) f <= 1'b0;
            end
            assign flag_o[i] = f;
        end else begin : g_none
            logic unused_in;
            assign unused_in = set_i[i] ^ clr_i[i];
            assign flag_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/clkrst_evt_regs.sv
// Module: clock-reset event flags, live status and interrupt enables.
// Assumes rst_n is the power-on reset only; wr_en is a one-cycle strobe;
// lock_in and scm_in are asynchronous levels.
module clkrst_evt_regs
    import clkrst_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rti_tick,
    input  logic              por_evt,
    input  logic              lvr_evt,
    input  logic              ila_evt,
    input  logic              lock_in,
    input  logic              scm_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr_en,
    output logic [REG_W-1:0]  rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_OFS);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_OFS);

    logic             lk_sync, sc_sync;
    logic             lk_stat, sc_stat;
    logic             lk_chg, sc_chg;
    logic [REG_W-1:0] set_vec, clr_vec, flags, en_q, stat_vec;
    logic             flag_sel, ien_sel;

    clkrst_sync #(.STAGES(SYNC_STAGES)) u_lk_sync (
        .clk(clk), .rst_n(rst_n), .d(lock_in), .q(lk_sync));
    clkrst_sync #(.STAGES(SYNC_STAGES)) u_sc_sync (
        .clk(clk), .rst_n(rst_n), .d(scm_in), .q(sc_sync));

    // lock is never reported while running on the self clock
    assign lk_stat = lk_sync & ~sc_sync;
    assign sc_stat = sc_sync;

    clkrst_chg_det u_lk_chg (.clk(clk), .rst_n(rst_n), .lvl(lk_stat), .chg(lk_chg));
    clkrst_chg_det u_sc_chg (.clk(clk), .rst_n(rst_n), .lvl(sc_stat), .chg(sc_chg));

    assign flag_sel = (addr == A_FLAG);
    assign ien_sel  = (addr == A_IEN);

    // gather the set sources into their bit positions
    always_comb begin
        set_vec          = '0;
        set_vec[B_TICK]  = rti_tick;
        set_vec[B_POR]   = por_evt;
        set_vec[B_LVR]   = lvr_evt;
        set_vec[B_LKCHG] = lk_chg;
        set_vec[B_ILA]   = ila_evt;
        set_vec[B_SCCHG] = sc_chg;
    end

    assign clr_vec = (wr_en && flag_sel) ? wdata : '0;

    clkrst_w1c_bank #(
        .W(REG_W), .MASK(STICKY_MASK), .RST_VAL(FLAG_RST)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flag_o(flags));

    // interrupt enable register, only implemented bits stored
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= '0;
        else if (wr_en && ien_sel) en_q <= wdata & IEN_MASK;
    end

    // live status bits placed beside the flags
    always_comb begin
        stat_vec         = '0;
        stat_vec[B_LKST] = lk_stat;
        stat_vec[B_SCST] = sc_stat;
    end

    // read mux; unmapped offsets read 0
    always_comb begin
        if (flag_sel)     rdata = flags | stat_vec;
        else if (ien_sel) rdata = en_q;
        else              rdata = '0;
    end

    assign irq = |(flags & en_q & IEN_MASK);
endmodule

// File: rtl/clkrst_evt_regs_chk.sv
// Module: assertion checker for clkrst_evt_regs, attached by bind.
// Assumes the bound signals are the top's flag bank, enable register
// and lock status.
module clkrst_evt_regs_chk
    import clkrst_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rti_tick,
    input logic              por_evt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [REG_W-1:0]  flags,
    input logic [REG_W-1:0]  en_q,
    input logic              lk_stat,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_OFS);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_OFS);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == FLAG_RST && en_q == '0 && !irq));

    // R4
    tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rti_tick |=> flags[B_TICK]);

    // R5
    por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> flags[B_POR]);

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FLAG && wdata[B_TICK] && !rti_tick) |=> !flags[B_TICK]);

    // R9
    ien_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IEN) |=> en_q == ($past(wdata) & IEN_MASK));

    // R6
    lock_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lk_stat) |=> flags[B_LKCHG]);

    // R10
    tick_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_tick && en_q[B_TICK] && !(wr_en && addr == A_IEN)) |=> irq);
endmodule

bind clkrst_evt_regs clkrst_evt_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rti_tick(rti_tick), .por_evt(por_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .flags(flags),
    .en_q(en_q), .lk_stat(lk_stat), .irq(irq));

// File: tb/clkrst_evt_regs_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks with hand-computed values.
module clkrst_evt_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rti_tick = 1'b0, por_evt = 1'b0, lvr_evt = 1'b0, ila_evt = 1'b0;
    logic       lock_in = 1'b0, scm_in = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkrst_evt_regs dut_i (
        .clk(clk), .rst_n(rst_n), .rti_tick(rti_tick), .por_evt(por_evt),
        .lvr_evt(lvr_evt), .ila_evt(ila_evt), .lock_in(lock_in), .scm_in(scm_in),
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata), .irq(irq));

    // reference model state
    logic [7:0] m_flag, m_en;
    bit         lk_q[$], sc_q[$];
    bit         m_lk, m_sc, m_lk_seen, m_sc_seen;

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        if (a == 3'd3) return m_flag | {4'b0, m_lk, 2'b0, m_sc};
        if (a == 3'd4) return m_en;
        return 8'h00;
    endfunction

    // model update on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 8'h40; m_en = 8'h00;
            lk_q = {1'b0, 1'b0}; sc_q = {1'b0, 1'b0};
            m_lk = 0; m_sc = 0; m_lk_seen = 0; m_sc_seen = 0;
        end else begin
            logic [7:0] setv, clrv;
            bit lk_raw, sc_raw;
            setv = {rti_tick, por_evt, lvr_evt, 1'b0, 1'b0, ila_evt, 1'b0, 1'b0};
            if (m_lk != m_lk_seen) setv[4] = 1'b1;
            if (m_sc != m_sc_seen) setv[1] = 1'b1;
            m_lk_seen = m_lk; m_sc_seen = m_sc;
            clrv = (wr_en && addr == 3'd3) ? wdata : 8'h00;
            m_flag = ((m_flag & ~clrv) | setv) & 8'hF6;
            if (wr_en && addr == 3'd4) m_en = wdata & 8'h92;
            lk_q.push_back(lock_in); void'(lk_q.pop_front());
            sc_q.push_back(scm_in);  void'(sc_q.pop_front());
            lk_raw = lk_q[0]; sc_raw = sc_q[0];
            m_sc = sc_raw;
            m_lk = lk_raw && !sc_raw;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // advance one edge and compare against the model
    task automatic step();
        @(posedge clk);
        #1;
        check(addr == 3'd3 ? "R2 model event reg" :
              addr == 3'd4 ? "R9 model enable reg" : "R12 model unmapped",
              rdata, exp_rd(addr));
        check("R10 model irq", {7'b0, irq}, {7'b0, |(m_flag & m_en)});
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic peek(input logic [2:0] a, input string tag, input logic [7:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    initial begin
        steps(3);
        rst_n = 1'b1;
        peek(3'd3, "R1 event reg after reset", 8'h40);
        peek(3'd4, "R1 enable reg after reset", 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);

        wr(3'd3, 8'h00);
        peek(3'd3, "R3 zero write keeps flags", 8'h40);
        wr(3'd3, 8'h40);
        peek(3'd3, "R3 one write clears por flag", 8'h00);

        rti_tick = 1'b1; step(); rti_tick = 1'b0;
        peek(3'd3, "R4 tick sets bit 7", 8'h80);

        wr(3'd4, 8'h80);
        check("R10 irq with tick enabled", {7'b0, irq}, 8'h01);
        wr(3'd4, 8'hFF);
        peek(3'd4, "R9 unused enable bits read 0", 8'h92);
        wr(3'd3, 8'h80);
        check("R10 irq drops after clear", {7'b0, irq}, 8'h00);
        wr(3'd4, 8'h00);

        por_evt = 1'b1; lvr_evt = 1'b1; ila_evt = 1'b1; step();
        por_evt = 1'b0; lvr_evt = 1'b0; ila_evt = 1'b0;
        peek(3'd3, "R5 R2 reset cause flags", 8'h64);
        wr(3'd3, 8'h20);
        peek(3'd3, "R3 partial clear", 8'h44);
        wr(3'd3, 8'hFF);
        peek(3'd3, "R3 clear all", 8'h00);

        addr = 3'd3;
        lock_in = 1'b1; steps(2);
        peek(3'd3, "R6 lock status after two edges", 8'h08);
        step();
        peek(3'd3, "R6 lock rise sets change flag", 8'h18);
        wr(3'd3, 8'h10);
        wr(3'd3, 8'h08);
        peek(3'd3, "R8 status ignores writes", 8'h08);
        lock_in = 1'b0; steps(2);
        peek(3'd3, "R6 lock status falls", 8'h00);
        step();
        peek(3'd3, "R6 lock fall sets change flag", 8'h10);
        wr(3'd3, 8'h10);

        lock_in = 1'b1; steps(3);
        wr(3'd3, 8'h10);
        peek(3'd3, "R6 locked and clean", 8'h08);
        scm_in = 1'b1; steps(2);
        peek(3'd3, "R7 R6 self clock forces lock low", 8'h01);
        step();
        peek(3'd3, "R7 both change flags set", 8'h13);
        wr(3'd4, 8'h02);
        check("R10 self clock irq", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h01);
        peek(3'd3, "R8 self clock status ignores write", 8'h13);
        wr(3'd3, 8'h12);
        check("R10 irq clear", {7'b0, irq}, 8'h00);
        scm_in = 1'b0; steps(3);
        peek(3'd3, "R7 leaving self clock", 8'h1A);
        wr(3'd3, 8'hFF);

        addr = 3'd3; wdata = 8'h80; wr_en = 1'b1; rti_tick = 1'b1;
        step();
        wr_en = 1'b0; rti_tick = 1'b0;
        peek(3'd3, "R11 set wins over clear", 8'h88);

        wr(3'd0, 8'hFF);
        peek(3'd0, "R12 unmapped reads 0", 8'h00);
        wr(3'd7, 8'hFF);
        peek(3'd7, "R12 top offset reads 0", 8'h00);
        peek(3'd3, "R12 unmapped write leaves flags", 8'h88);
        peek(3'd4, "R12 unmapped write leaves enables", 8'h02);

        rst_n = 1'b0; step(); rst_n = 1'b1;
        peek(3'd3, "R1 second reset", 8'h40);
        steps(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule